// File: doc/BRIEF.md
# Conditional Skip Evaluator

This block decides whether a conditional-skip instruction skips the next instruction. On each cycle in which `exec_i` is high it reads the condition field of the instruction address. It tests the accumulator, the sign of the in-out register, a sticky overflow bit, six console sense switches and six program flags. It raises `skip_o` in the same cycle when the test passes. The program counter logic uses `skip_o` to advance one extra position. The block needs no memory access, and the result is ready within one cycle.

Several condition bits may be set in one instruction. The skip is then the inclusive OR of all the tests that were selected. The block also keeps the overflow bit:
- an overflow event from the arithmetic unit sets it;
- the start control clears it;
- running the overflow test clears it.

Bits are numbered from 0 at the least significant end. The accumulator sign is its most significant bit.

Top module: `skip_eval`

## Requirements
- R1: With address bit 6 set (octal 100), the skip happens when every accumulator bit is 0. An all-ones accumulator (minus zero) does not satisfy this test.
- R2: Address bit 7 (octal 200) skips when the accumulator sign bit is 0. Address bit 8 (octal 400) skips when the sign bit is 1.
- R3: Address bit 10 (octal 2000) skips when `io_sign_i` is 0.
- R4: Address bit 9 (octal 1000) skips when the overflow bit, as it stood before the clock edge, is 0. Executing this test clears the overflow bit at the next edge.
- R5: `arith_ovf_i` sets the overflow bit at the next edge. The bit stays set with no other source of change. When an overflow event and the overflow test fall in the same cycle, the bit ends up set.
- R6: `start_i` clears the overflow bit at the next edge. It wins over an overflow event in the same cycle.
- R7: Address bits 5:3 choose the switch test. Code 0 makes no test. Code k from 1 to 6 skips when `sense_sw_i[k-1]` is 0. Code 7 skips only when all six switches are 0.
- R8: Address bits 2:0 choose the flag test. Code 0 makes no test. Code k from 1 to 6 skips when `prog_flag_i[k-1]` is 0. Code 7 skips only when all six flags are 0.
- R9: When more than one test is selected, `skip_o` is the inclusive OR of the selected tests.
- R10: `skip_o` is 0 whenever `exec_i` is 0, whatever the other inputs are.
- R11: After reset, `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| exec_i | input | 1 | A skip instruction is executing this cycle |
| addr_i | input | 11 | Condition field of the instruction address (bits 10:0) |
| acc_i | input | 36 | Accumulator contents |
| io_sign_i | input | 1 | Sign bit of the in-out register |
| sense_sw_i | input | 6 | Sense switches; bit k-1 is switch k |
| prog_flag_i | input | 6 | Program flags; bit k-1 is flag k |
| arith_ovf_i | input | 1 | An arithmetic operation overflowed this cycle |
| start_i | input | 1 | Start control; clears the overflow bit |
| skip_o | output | 1 | Skip the next instruction |
| ovf_o | output | 1 | Current overflow bit |

## Verification
Every combination of the five single-bit tests is crossed with four accumulator values: zero, minus zero, sign only, and a small positive value. Each combination is also tried with both in-out signs. This separates the zero test from the sign tests and shows that the results are ORed. The switch and flag select codes are each swept over all 64 switch or flag patterns. That separates a single-line test from the all-zero code and from the empty code. Fixed sequences drive the overflow bit through set, hold, test-and-clear, set against test, and start against set. A cross of the two select fields, plus a sweep with `exec_i` low, covers the OR and gating rules.

// File: rtl/skip_pkg.sv
package skip_pkg;
  // Condition bit positions within the address field
  localparam int unsigned BIT_ACC_ZERO  = 6;
  localparam int unsigned BIT_ACC_PLUS  = 7;
  localparam int unsigned BIT_ACC_MINUS = 8;
  localparam int unsigned BIT_OVF_ZERO  = 9;
  localparam int unsigned BIT_IO_PLUS   = 10;
  // Select sub-fields
  localparam int unsigned SEL_W         = 3;
  localparam int unsigned SW_SEL_LO     = 3;
  localparam int unsigned FLAG_SEL_LO   = 0;

  typedef struct packed {
    logic acc_zero;
    logic acc_plus;
    logic acc_minus;
    logic ovf_zero;
    logic io_plus;
    logic sw_zero;
    logic flag_zero;
  } skip_hits_t;
endpackage

// File: rtl/skip_rst_sync.sv
module skip_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/skip_field_sel.sv
module skip_field_sel #(
  parameter int unsigned N_LINES = 6,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [N_LINES-1:0] lines,
  output logic               hit
);
  // Highest code means "every line must be zero"; code 0 selects nothing.
  localparam int unsigned ALL_CODE = (1 << SEL_W) - 1;

  logic [N_LINES-1:0] line_hit;
  logic               all_hit;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign line_hit[g] = (sel == SEL_W'(g + 1)) && !lines[g];
  end

  assign all_hit = (sel == SEL_W'(ALL_CODE)) && (lines == '0);
  assign hit     = (|line_hit) | all_hit;
endmodule

// File: rtl/skip_ovf_reg.sv
module skip_ovf_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic start_i,
  input  logic test_i,
  output logic ovf_q
);
  logic ovf_d;
  logic ovf_en;

  // Priority: start clear, then overflow set, then test clear
  always_comb begin
    ovf_en = start_i | set_i | test_i;
    if (start_i)    ovf_d = 1'b0;
    else if (set_i) ovf_d = 1'b1;
    else            ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !ovf_q);
  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !start_i) |=> ovf_q);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !start_i && !test_i) |=> ovf_q);
  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i |=> !$rose(ovf_q));
  a_r4_test_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (test_i && !set_i) |=> !ovf_q);
endmodule

// File: rtl/skip_eval.sv
module skip_eval #(
  parameter int unsigned ACC_W  = 36,
  parameter int unsigned N_SW   = 6,
  parameter int unsigned N_FLAG = 6,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              io_sign_i,
  input  logic [N_SW-1:0]   sense_sw_i,
  input  logic [N_FLAG-1:0] prog_flag_i,
  input  logic              arith_ovf_i,
  input  logic              start_i,
  output logic              skip_o,
  output logic              ovf_o
);
  import skip_pkg::*;

  localparam int unsigned SIGN_BIT = ACC_W - 1;

  logic       rst_sync_n;
  logic       ovf_q;
  logic       ovf_test;
  logic       sw_hit;
  logic       flag_hit;
  skip_hits_t hits;

  skip_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  skip_field_sel #(.N_LINES(N_SW), .SEL_W(SEL_W)) u_sw_sel (
    .sel   (addr_i[SW_SEL_LO +: SEL_W]),
    .lines (sense_sw_i),
    .hit   (sw_hit)
  );

  skip_field_sel #(.N_LINES(N_FLAG), .SEL_W(SEL_W)) u_flag_sel (
    .sel   (addr_i[FLAG_SEL_LO +: SEL_W]),
    .lines (prog_flag_i),
    .hit   (flag_hit)
  );

  assign ovf_test = exec_i & addr_i[BIT_OVF_ZERO];

  skip_ovf_reg u_ovf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (arith_ovf_i),
    .start_i (start_i),
    .test_i  (ovf_test),
    .ovf_q   (ovf_q)
  );

  always_comb begin
    hits.acc_zero  = addr_i[BIT_ACC_ZERO]  && (acc_i == '0);
    hits.acc_plus  = addr_i[BIT_ACC_PLUS]  && !acc_i[SIGN_BIT];
    hits.acc_minus = addr_i[BIT_ACC_MINUS] &&  acc_i[SIGN_BIT];
    hits.ovf_zero  = addr_i[BIT_OVF_ZERO]  && !ovf_q;
    hits.io_plus   = addr_i[BIT_IO_PLUS]   && !io_sign_i;
    hits.sw_zero   = sw_hit;
    hits.flag_zero = flag_hit;
    skip_o         = exec_i && (|hits);
  end

  assign ovf_o = ovf_q;

  a_r10_idle_no_skip: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exec_i |-> !skip_o);
  a_r1_zero_skips: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && addr_i[BIT_ACC_ZERO] && acc_i == '0) |-> skip_o);
  a_r1_minus_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && addr_i == ADDR_W'(1 << BIT_ACC_ZERO) && (&acc_i)) |-> !skip_o);
  a_r2_plus: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && addr_i[BIT_ACC_PLUS] && !acc_i[SIGN_BIT]) |-> skip_o);
  a_r2_minus: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && addr_i[BIT_ACC_MINUS] && acc_i[SIGN_BIT]) |-> skip_o);
  a_r3_io_plus: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && addr_i[BIT_IO_PLUS] && !io_sign_i) |-> skip_o);
  a_r4_ovf_skip: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && addr_i[BIT_OVF_ZERO] && !ovf_o) |-> skip_o);
  a_r7_all_switches: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && addr_i[SW_SEL_LO +: SEL_W] == '1 && sense_sw_i == '0) |-> skip_o);
  a_r8_all_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && addr_i[FLAG_SEL_LO +: SEL_W] == '1 && prog_flag_i == '0) |-> skip_o);
  a_r9_empty_field: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && addr_i == '0) |-> !skip_o);
endmodule

// File: tb/skip_eval_tb.sv
`timescale 1ns/1ps
module skip_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_i;
  logic [10:0] addr_i;
  logic [35:0] acc_i;
  logic        io_sign_i;
  logic [5:0]  sense_sw_i;
  logic [5:0]  prog_flag_i;
  logic        arith_ovf_i;
  logic        start_i;
  logic        skip_o;
  logic        ovf_o;

  int checks = 0;
  int failures = 0;
  bit model_ovf = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  skip_eval u_dut (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .addr_i(addr_i), .acc_i(acc_i),
    .io_sign_i(io_sign_i), .sense_sw_i(sense_sw_i), .prog_flag_i(prog_flag_i),
    .arith_ovf_i(arith_ovf_i), .start_i(start_i), .skip_o(skip_o), .ovf_o(ovf_o)
  );

  function automatic bit sel_test(input logic [2:0] s, input logic [5:0] v);
    if (s == 3'd7) return (v == 6'd0);
    if (s >= 3'd1 && s <= 3'd6) return !v[s - 1];
    return 1'b0;
  endfunction

  function automatic bit exp_skip(input bit e, input logic [10:0] a, input logic [35:0] ac,
                                  input bit io, input logic [5:0] sw, input logic [5:0] fl,
                                  input bit ov);
    bit r = 1'b0;
    if (!e) return 1'b0;
    if (a[6] && ac == 36'd0) r = 1'b1;
    if (a[7] && !ac[35])     r = 1'b1;
    if (a[8] &&  ac[35])     r = 1'b1;
    if (a[9] && !ov)         r = 1'b1;
    if (a[10] && !io)        r = 1'b1;
    if (sel_test(a[5:3], sw)) r = 1'b1;
    if (sel_test(a[2:0], fl)) r = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b addr=%o t=%0t", tag, act, exp, addr_i, $time);
    end
  endtask

  task automatic step(input bit e, input logic [10:0] a, input logic [35:0] ac, input bit io,
                      input logic [5:0] sw, input logic [5:0] fl, input bit aov, input bit st,
                      input string tag);
    string otag;
    @(negedge clk);
    exec_i = e; addr_i = a; acc_i = ac; io_sign_i = io;
    sense_sw_i = sw; prog_flag_i = fl; arith_ovf_i = aov; start_i = st;
    #1;
    check(tag, skip_o, exp_skip(e, a, ac, io, sw, fl, model_ovf));
    @(posedge clk);
    if (st)             begin model_ovf = 1'b0; otag = "R6"; end
    else if (aov)       begin model_ovf = 1'b1; otag = "R5"; end
    else if (e && a[9]) begin model_ovf = 1'b0; otag = "R4"; end
    else                otag = "R5";
    #1;
    check(otag, ovf_o, model_ovf);
  endtask

  function automatic logic [35:0] acc_pat(input int p);
    case (p)
      0: return 36'd0;
      1: return '1;
      2: return 36'h8_0000_0000;
      default: return 36'd5;
    endcase
  endfunction

  function automatic string bit_tag(input int c);
    case (c)
      1: return "R1";
      2, 4: return "R2";
      8: return "R4";
      16: return "R3";
      default: return "R9";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; exec_i = 0; addr_i = '0; acc_i = '0; io_sign_i = 0;
    sense_sw_i = '0; prog_flag_i = '0; arith_ovf_i = 0; start_i = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R11", ovf_o, 1'b0);
    check("R10", skip_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R11", ovf_o, 1'b0);

    // Single-bit tests and their combinations (bits 6..10)
    for (int c = 0; c < 32; c++)
      for (int p = 0; p < 4; p++)
        for (int io = 0; io < 2; io++)
          step(1'b1, 11'(c << 6), acc_pat(p), io[0], 6'h3f, 6'h3f,
               ((c + p + io) % 3) == 0, 1'b0, bit_tag(c));

    // Switch select field over every switch pattern
    for (int s = 0; s < 8; s++)
      for (int v = 0; v < 64; v++)
        step(1'b1, 11'(s << 3), 36'd1, 1'b1, 6'(v), 6'h3f, 1'b0, 1'b0, "R7");

    // Flag select field over every flag pattern
    for (int s = 0; s < 8; s++)
      for (int v = 0; v < 64; v++)
        step(1'b1, 11'(s), 36'd1, 1'b1, 6'h3f, 6'(v), 1'b0, 1'b0, "R8");

    // Cross of both select fields
    for (int s1 = 0; s1 < 8; s1++)
      for (int s2 = 0; s2 < 8; s2++)
        for (int k = 0; k < 4; k++)
          step(1'b1, 11'((s1 << 3) | s2), 36'd1, 1'b1, 6'(k * 21), 6'(63 - k * 17),
               1'b0, 1'b0, "R9");

    // Not executing: no skip whatever the field says
    for (int a = 0; a < 2048; a += 37)
      step(1'b0, 11'(a), 36'd0, 1'b0, 6'd0, 6'd0, (a % 2) == 1, 1'b0, "R10");

    // Overflow bit corner sequences
    step(1'b0, 11'd0, 36'd1, 1'b1, 6'h3f, 6'h3f, 1'b1, 1'b1, "R6");  // start beats set
    step(1'b0, 11'd0, 36'd1, 1'b1, 6'h3f, 6'h3f, 1'b1, 1'b0, "R5");  // set
    step(1'b0, 11'd0, 36'd1, 1'b1, 6'h3f, 6'h3f, 1'b0, 1'b0, "R5");  // hold
    step(1'b1, 11'o1000, 36'd1, 1'b1, 6'h3f, 6'h3f, 1'b1, 1'b0, "R5"); // set vs test
    step(1'b1, 11'o1000, 36'd1, 1'b1, 6'h3f, 6'h3f, 1'b0, 1'b0, "R4"); // no skip, clears
    step(1'b1, 11'o1000, 36'd1, 1'b1, 6'h3f, 6'h3f, 1'b0, 1'b0, "R4"); // skip now
    step(1'b0, 11'd0, 36'd1, 1'b1, 6'h3f, 6'h3f, 1'b1, 1'b0, "R5");
    step(1'b0, 11'd0, 36'd1, 1'b1, 6'h3f, 6'h3f, 1'b0, 1'b1, "R6");  // start clears
    step(1'b1, 11'o3000, 36'd1, 1'b1, 6'h3f, 6'h3f, 1'b0, 1'b0, "R9");
    step(1'b1, 11'o0100, '1, 1'b1, 6'h3f, 6'h3f, 1'b0, 1'b0, "R1");   // minus zero

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule